// File: doc/BRIEF.md
# Synthetic-Sample ADC Register Block

This block is a 32-bit memory-mapped register file that stands in for an analog-to-digital converter where no converter exists. It is used in system models and early bring-up, where firmware needs to program control, sampling-time, threshold and sequence registers and then read plausible, predictable conversion results. Software starts a conversion by setting a start bit together with a converter-enable bit. The next read of the sample register returns a value from a deterministic counter. That read also clears the start request, so each request yields exactly one sample.

Each sample advances a stored accumulator by 7 and masks it to the chosen resolution. The value can then be returned in left-aligned form, where the stored value is doubled and its low nibble is cleared. The status word can only be cleared, never set, from the bus. The four injected-offset words hold 12 bits each. Reading an injected-data word returns the stored data minus its matching offset. All other words are plain storage. The bus is a single-cycle register port, and read data is registered.

Top module: `adcSampleShim`

## Requirements
- R1: After reset, every word reads 0, except the upper-limit word at offset 0x24, which reads 0x00000FFF.
- R2: Word offsets are: status 0x00, control A 0x04, control B 0x08, sample-time 0x0C/0x10, injected offsets 0x14..0x20, upper limit 0x24, lower limit 0x28, sequence 0x2C..0x34, injected sequence 0x38, injected data 0x3C..0x48, sample 0x4C. Any other address (including 0x100 and above, and non-word-aligned addresses) reads 0, and writes to it change no word.
- R3: A write to status sets it to its old value ANDed with the written data's bits 5:0, so no bit can be set from the bus.
- R4: Control B stores all 32 written bits, but a read returns only bits 27:0, with bits 31:28 read as 0.
- R5: A read of the sample word returns 0 and changes no state unless both control B bit 0 (enable) and control B bit 30 (start) are 1.
- R6: A sample-word read that produces a sample clears control B bit 30, so a second read without a new start returns 0.
- R7: A produced sample sets the accumulator to (accumulator + 7) masked by control A bits 25:24: code 0 keeps 12 bits, code 1 keeps 10, code 2 keeps 8, code 3 keeps 6.
- R8: With control B bit 11 set, the returned sample is (accumulator << 1) & 0xFFF0. With the bit clear, the accumulator is returned as is. The accumulator itself is never shifted.
- R9: Writes to the injected-offset words keep only the written bits 11:0.
- R10: A read of injected-data word n returns the stored data minus offset n, modulo 2^32.
- R11: The sample-time, limit, sequence and injected-sequence words read back exactly what was last written.
- R12: Read data appears on the cycle after read enable and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 32 | Byte address of the access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Registered read data |

## Verification
A corrupted accumulator shows as the wrong value on the very next produced sample, one cycle after the read, and every later sample stays offset from the expected sequence. A start bit that is not cleared shows as a non-zero second read. A lost start bit shows as a zero where a sample was expected. Decode faults show as a word that does not read back, or as a word changed by a write to an unmapped address, on the next read of that word.

// File: rtl/adcSampleShimPkg.sv
package adcSampleShimPkg;
  localparam int SEL_W     = 5;
  localparam int REG_COUNT = 20;
  localparam int NUM_INJ   = 4;
  localparam int NUM_SEQ   = 3;
  localparam int NUM_SAMPT = 2;

  localparam logic [SEL_W-1:0] SEL_STATUS     = 5'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL_A     = 5'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL_B     = 5'd2;
  localparam logic [SEL_W-1:0] SAMPT_BASE     = 5'd3;
  localparam logic [SEL_W-1:0] INJ_OFF_BASE   = 5'd5;
  localparam logic [SEL_W-1:0] SEL_LIMIT_HI   = 5'd9;
  localparam logic [SEL_W-1:0] SEL_LIMIT_LO   = 5'd10;
  localparam logic [SEL_W-1:0] SEQ_BASE       = 5'd11;
  localparam logic [SEL_W-1:0] SEL_INJ_SEQ    = 5'd14;
  localparam logic [SEL_W-1:0] INJ_DATA_BASE  = 5'd15;
  localparam logic [SEL_W-1:0] SEL_SAMPLE     = 5'd19;

  localparam int ENABLE_BIT = 0;
  localparam int ALIGN_BIT  = 11;
  localparam int RES_LSB    = 24;
  localparam int START_BIT  = 30;
  localparam int CTRL_B_VISIBLE = 28;
  localparam int STATUS_W   = 6;
  localparam int OFFSET_W   = 12;

  typedef struct packed {
    logic             rdReq;
    logic             rdHit;
    logic             wrHit;
    logic [SEL_W-1:0] sel;
    logic             convFire;
  } busStrobe_t;
endpackage

// File: rtl/adcSampleShimCtrl.sv
module adcSampleShimCtrl
  import adcSampleShimPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WINDOW_BYTES = 256
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              convEnable,
  input  logic              convStart,
  output busStrobe_t        strobe
);
  localparam int WIN_BITS = $clog2(WINDOW_BYTES);
  localparam int IDX_W    = WIN_BITS - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             inWindow;

  assign wordIdx  = regAddr[WIN_BITS-1:2];
  assign inWindow = ((regAddr >> WIN_BITS) == '0) && (regAddr[1:0] == 2'b00)
                    && (wordIdx < IDX_W'(REG_COUNT));

  always_comb begin
    strobe.rdReq    = regRdEn;
    strobe.rdHit    = regRdEn && inWindow;
    strobe.wrHit    = regWrEn && inWindow;
    strobe.sel      = wordIdx[SEL_W-1:0];
    strobe.convFire = strobe.rdHit && (strobe.sel == SEL_SAMPLE)
                      && convEnable && convStart;
  end
endmodule

// File: rtl/adcSampleShimDatapath.sv
module adcSampleShimDatapath
  import adcSampleShimPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 12,
  parameter int STEP     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              convEnable,
  output logic              convStart
);
  localparam logic [DATA_W-1:0] LIMIT_HI_RST = DATA_W'((1 << SAMPLE_W) - 1);
  localparam logic [DATA_W-1:0] ALIGN_MASK   = DATA_W'(((1 << (SAMPLE_W + 4)) - 1) & ~15);

  logic [DATA_W-1:0]   statusReg, ctrlA, ctrlB, limitHi, limitLo, injSeq;
  logic [DATA_W-1:0]   samplTime [NUM_SAMPT];
  logic [DATA_W-1:0]   seqReg    [NUM_SEQ];
  logic [DATA_W-1:0]   injData   [NUM_INJ];
  logic [OFFSET_W-1:0] injOff    [NUM_INJ];
  logic [DATA_W-1:0]   injRead   [NUM_INJ];
  logic [SAMPLE_W-1:0] sampleAcc, resMask, nextAcc;
  logic [DATA_W-1:0]   sampleOut, rdMux;
  logic                wrCtrlB;

  assign convEnable = ctrlB[ENABLE_BIT];
  assign convStart  = ctrlB[START_BIT];
  assign wrCtrlB    = strobe.wrHit && (strobe.sel == SEL_CTRL_B);

  always_comb begin
    resMask   = SAMPLE_W'((1 << (SAMPLE_W - 2 * int'(ctrlA[RES_LSB +: 2]))) - 1);
    nextAcc   = (sampleAcc + SAMPLE_W'(STEP)) & resMask;
    sampleOut = ctrlB[ALIGN_BIT] ? ((DATA_W'(nextAcc) << 1) & ALIGN_MASK)
                                 : DATA_W'(nextAcc);
  end

  generate
    for (genvar g = 0; g < NUM_INJ; g++) begin : gInjRead
      assign injRead[g] = injData[g] - DATA_W'(injOff[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      ctrlA     <= '0;
      ctrlB     <= '0;
      limitHi   <= LIMIT_HI_RST;
      limitLo   <= '0;
      injSeq    <= '0;
      sampleAcc <= '0;
      for (int i = 0; i < NUM_SAMPT; i++) samplTime[i] <= '0;
      for (int i = 0; i < NUM_SEQ; i++) seqReg[i] <= '0;
      for (int i = 0; i < NUM_INJ; i++) begin
        injData[i] <= '0;
        injOff[i]  <= '0;
      end
    end else begin
      if (strobe.convFire) sampleAcc <= nextAcc;
      if (wrCtrlB) ctrlB <= wrData;
      else if (strobe.convFire) ctrlB[START_BIT] <= 1'b0;
      if (strobe.wrHit) begin
        case (strobe.sel)
          SEL_STATUS:   statusReg <= statusReg & DATA_W'(wrData[STATUS_W-1:0]);
          SEL_CTRL_A:   ctrlA     <= wrData;
          SEL_LIMIT_HI: limitHi   <= wrData;
          SEL_LIMIT_LO: limitLo   <= wrData;
          SEL_INJ_SEQ:  injSeq    <= wrData;
          default: ;
        endcase
        for (int i = 0; i < NUM_SAMPT; i++)
          if (strobe.sel == SEL_W'(SAMPT_BASE + i)) samplTime[i] <= wrData;
        for (int i = 0; i < NUM_SEQ; i++)
          if (strobe.sel == SEL_W'(SEQ_BASE + i)) seqReg[i] <= wrData;
        for (int i = 0; i < NUM_INJ; i++) begin
          if (strobe.sel == SEL_W'(INJ_OFF_BASE + i)) injOff[i] <= wrData[OFFSET_W-1:0];
          if (strobe.sel == SEL_W'(INJ_DATA_BASE + i)) injData[i] <= wrData;
        end
      end
    end
  end

  always_comb begin
    rdMux = '0;
    case (strobe.sel)
      SEL_STATUS:   rdMux = statusReg;
      SEL_CTRL_A:   rdMux = ctrlA;
      SEL_CTRL_B:   rdMux = DATA_W'(ctrlB[CTRL_B_VISIBLE-1:0]);
      SEL_LIMIT_HI: rdMux = limitHi;
      SEL_LIMIT_LO: rdMux = limitLo;
      SEL_INJ_SEQ:  rdMux = injSeq;
      SEL_SAMPLE:   rdMux = strobe.convFire ? sampleOut : '0;
      default: ;
    endcase
    for (int i = 0; i < NUM_SAMPT; i++)
      if (strobe.sel == SEL_W'(SAMPT_BASE + i)) rdMux = samplTime[i];
    for (int i = 0; i < NUM_SEQ; i++)
      if (strobe.sel == SEL_W'(SEQ_BASE + i)) rdMux = seqReg[i];
    for (int i = 0; i < NUM_INJ; i++) begin
      if (strobe.sel == SEL_W'(INJ_OFF_BASE + i)) rdMux = DATA_W'(injOff[i]);
      if (strobe.sel == SEL_W'(INJ_DATA_BASE + i)) rdMux = injRead[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdReq) rdData <= strobe.rdHit ? rdMux : '0;
  end

  // R3: a status write never raises a bit
  assert_status_clear_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHit && strobe.sel == SEL_STATUS |=> (statusReg & ~$past(statusReg)) == '0);

  // R4: hidden top bits of control B
  assert_ctrlb_top_hidden_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdHit && strobe.sel == SEL_CTRL_B |=> rdData[DATA_W-1:CTRL_B_VISIBLE] == '0);

  // R5: an unarmed sample read returns zero and leaves the accumulator
  assert_idle_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdHit && strobe.sel == SEL_SAMPLE && !strobe.convFire
    |=> rdData == '0 && $stable(sampleAcc));

  // R6: one sample per start request
  assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.convFire && !wrCtrlB |=> !convStart);

  // R7: accumulator stays inside the resolution mask in force at conversion
  assert_acc_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.convFire |=> (sampleAcc & ~$past(resMask)) == '0);

  // R8: aligned samples have a clear low nibble and nothing above bit 15
  assert_align_shape_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.convFire && ctrlB[ALIGN_BIT] |=> rdData[3:0] == 4'h0 && rdData[DATA_W-1:16] == '0);
endmodule

// File: rtl/adcSampleShim.sv
module adcSampleShim
  import adcSampleShimPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int WINDOW_BYTES = 256,
  parameter int SAMPLE_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData
);
  busStrobe_t strobe;
  logic       convEnable, convStart;

  adcSampleShimCtrl #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .convEnable(convEnable), .convStart(convStart), .strobe(strobe)
  );

  adcSampleShimDatapath #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .rdData(regRdData), .convEnable(convEnable), .convStart(convStart)
  );
endmodule

// File: tb/adcSampleShim_tb.sv
`timescale 1ns/1ps
module adcSampleShim_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] regAddr = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  int modelAcc = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen;

  always #2.5 clk = ~clk;

  adcSampleShim u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rdSeen <= 1'b0; else rdSeen <= regRdEn;

  // monitor: one read result is due on the cycle after each read enable
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (regRdData !== e) begin
        nFails++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, regRdData, e);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    regAddr = a; regRdEn = 1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    regRdEn = 0;
  endtask

  // arm and read one sample; model from R7/R8
  task automatic convert(input int res, input bit align, input string t);
    logic [31:0] e;
    int mask;
    mask = (1 << (12 - 2 * res)) - 1;
    modelAcc = (modelAcc + 7) & mask;
    e = align ? ((modelAcc << 1) & 32'hFFF0) : modelAcc;
    wr(32'h08, 32'h4000_0001 | (align ? 32'h800 : 0));
    rd(32'h4C, e, t);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values
    rd(32'h00, 0, "R1 status");
    rd(32'h04, 0, "R1 ctrlA");
    rd(32'h08, 0, "R1 ctrlB");
    rd(32'h24, 32'hFFF, "R1 upper limit");
    rd(32'h28, 0, "R1 lower limit");
    rd(32'h3C, 0, "R1 injected data");
    rd(32'h4C, 0, "R1 sample idle");
    // R12 read data holds between reads
    rd(32'h24, 32'hFFF, "R12 read");
    repeat (3) @(negedge clk);
    nChecks++;
    if (regRdData !== 32'hFFF) begin
      nFails++;
      $display("FAIL R12 hold: got 0x%08h expected 0x%08h", regRdData, 32'hFFF);
    end
    // R11 plain storage
    wr(32'h0C, 32'hDEAD_BEEF); wr(32'h10, 32'h1234_5678);
    wr(32'h24, 32'hA5A5_0F0F); wr(32'h28, 32'h0000_0001);
    wr(32'h2C, 32'h1111_2222); wr(32'h30, 32'h3333_4444);
    wr(32'h34, 32'h5555_6666); wr(32'h38, 32'hFFFF_0000);
    rd(32'h0C, 32'hDEAD_BEEF, "R11 sample time 1");
    rd(32'h10, 32'h1234_5678, "R11 sample time 2");
    rd(32'h24, 32'hA5A5_0F0F, "R11 upper limit");
    rd(32'h28, 32'h0000_0001, "R11 lower limit");
    rd(32'h2C, 32'h1111_2222, "R11 seq 1");
    rd(32'h30, 32'h3333_4444, "R11 seq 2");
    rd(32'h34, 32'h5555_6666, "R11 seq 3");
    rd(32'h38, 32'hFFFF_0000, "R11 injected seq");
    // R4 hidden top bits, start bit still stored
    wr(32'h08, 32'h7000_0001);
    rd(32'h08, 32'h0000_0001, "R4 ctrlB masked read");
    modelAcc = 7;
    rd(32'h4C, 32'd7, "R4/R7 hidden start bit fires");
    // R6 start consumed
    rd(32'h4C, 0, "R6 second read after one sample");
    rd(32'h08, 32'h0000_0001, "R6 start bit cleared");
    // R5 partial arming
    wr(32'h08, 32'h0000_0001);
    rd(32'h4C, 0, "R5 enable only");
    wr(32'h08, 32'h4000_0000);
    rd(32'h4C, 0, "R5 start only");
    convert(0, 0, "R5/R7 accumulator unchanged by idle reads");
    // R7 resolution codes
    wr(32'h04, 32'h0200_0000);
    for (int i = 0; i < 40; i++) convert(2, 0, "R7 8-bit");
    wr(32'h04, 32'h0300_0000);
    for (int i = 0; i < 12; i++) convert(3, 0, "R7 6-bit");
    wr(32'h04, 32'h0100_0000);
    for (int i = 0; i < 10; i++) convert(1, 0, "R7 10-bit");
    wr(32'h04, 32'h0000_0000);
    for (int i = 0; i < 6; i++) convert(0, 0, "R7 12-bit");
    // R8 alignment
    for (int i = 0; i < 4; i++) convert(0, 1, "R8 aligned");
    convert(0, 0, "R8 accumulator not shifted");
    // R9/R10 injected offsets and data
    wr(32'h14, 32'hFFFF_F123);
    rd(32'h14, 32'h0000_0123, "R9 offset width");
    wr(32'h3C, 32'h0000_0100);
    rd(32'h3C, 32'hFFFF_FFDD, "R10 data minus offset wraps");
    wr(32'h20, 32'h0000_0ABC);
    wr(32'h48, 32'h0001_0000);
    rd(32'h48, 32'h0000_F544, "R10 fourth channel");
    // R3 status cannot be set
    wr(32'h00, 32'hFFFF_FFFF);
    rd(32'h00, 0, "R3 status write");
    // R2 unmapped addresses
    wr(32'h04, 32'h0000_00AA);
    wr(32'h104, 32'h1234_5678);
    wr(32'h05, 32'h5555_5555);
    wr(32'h50, 32'h7777_7777);
    rd(32'h04, 32'h0000_00AA, "R2 ctrlA untouched by unmapped writes");
    rd(32'h104, 0, "R2 above window");
    rd(32'h50, 0, "R2 past last word");
    rd(32'h05, 0, "R2 misaligned");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule